// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the register file of a 32-bit RISC core whose visible register set changes with the processor mode. Software names sixteen registers with a 4-bit number. Numbers 0 to 14 resolve to one of thirty physical words, and the resolution depends on the mode field held in the current status word. Number 15 stands for the program counter. The block has two combinational read ports and one write port that takes effect on the clock edge. A privileged access select redirects numbers 8 to 14 to the copies owned by user and system mode.

The block also holds the current status word and five saved status words, one for each exception mode. An exception request names a target mode. Taking it copies the current status into that mode's saved word, switches the mode field and masks interrupts. A restore request copies the saved word of the current mode back into the current status. The status words keep four condition flags (bits 31:28), the interrupt mask (bit 7), the fast-interrupt mask (bit 6) and the 5-bit mode field (bits 4:0). Every other bit reads as zero. The mode codes are 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined and 11111 system.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register reads 0, the current status reads 0x000000D3 (supervisor, both interrupt masks set), the saved status output reads 0 and the flush strobe is low.
- R2: Numbers 0 to 7 address the same eight physical words in every mode.
- R3: Numbers 8 to 12 address one shared set of five words in every mode except fast-interrupt mode, which uses five words of its own.
- R4: Numbers 13 and 14 address a separate pair of words in each of the five exception modes; user and system mode share one pair.
- R5: A read of number 15 returns pc_i plus 8, modulo 2^32. A write to number 15 leaves every stored register unchanged. In the cycle after the write edge it drives branch_o with the written data and raises flush_o for exactly one cycle.
- R6: When a read and a write address the same physical word in one cycle, the read returns the old value; the new value is visible from the next cycle.
- R7: With usr_bank high in a privileged mode, numbers 8 to 14 on all three ports resolve to the user/system copies; in user mode usr_bank has no effect.
- R8: An exception request to an exception mode copies the current status into that mode's saved word, sets the mode field to the request, sets bit 7, and sets bit 6 only for the fast-interrupt target; flags are kept. A request naming user, system or an unlisted code has no effect.
- R9: In user mode a write to the current status changes only bits 31:28. In a privileged mode it writes all kept bits (data AND 0xF00000DF).
- R10: A saved-status write lands in the current mode's saved word, masked with 0xF00000DF. In user or system mode it has no effect, and spsr_o reads 0 there.
- R11: A restore request in an exception mode copies that mode's saved word into the current status; in user or system mode it has no effect.
- R12: A mode field holding an unlisted code is treated as user mode: user/system register copies, no privilege, no saved word.
- R13: When requests coincide, an exception request wins over a restore, and a restore wins over a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| usr_bank | input | 1 | Privileged access to user/system copies of numbers 8 to 14 |
| pc_i | input | 32 | Address of the current instruction |
| branch_o | output | 32 | Target written to number 15 |
| flush_o | output | 1 | One-cycle strobe after a write to number 15 |
| psr_wr | input | 1 | Status write request |
| psr_saved_sel | input | 1 | 1 selects the saved status word of the current mode, 0 the current status |
| psr_wdata | input | 32 | Status write data |
| exc_take | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the exception |
| psr_restore | input | 1 | Copy the current mode's saved status into the current status |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status word of the current mode, 0 in user or system mode |

## Verification
A wrong bank decode shows up at a read port at once, in the same cycle the number is presented. The value returned then belongs to a neighbouring mode's copy, so the sweep writes a value that encodes both the writing mode and the number, and reads every number back in every mode. A corrupted status word shows on cpsr_o or spsr_o on the first clock edge after the request that produced it. It also shows later, through the register bank the wrong mode field selects. A missing or stretched branch strobe shows on flush_o one cycle after the write to number 15.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    localparam int N_BANK    = 6;
    localparam int N_EXC     = N_BANK - 1;
    localparam int N_LOW     = 8;
    localparam int N_HIGH    = 5;
    localparam int N_PAIR    = 2;
    localparam int FIQ_BASE  = N_LOW + N_HIGH;
    localparam int PAIR_BASE = N_LOW + 2 * N_HIGH;
    localparam int N_GPR     = PAIR_BASE + N_PAIR * N_BANK;
    localparam int PHYS_W    = $clog2(N_GPR);
    localparam int IDX_W     = 4;
    localparam int PSR_W     = 32;

    localparam logic [PSR_W-1:0] PSR_KEEP  = 32'hF000_00DF;
    localparam logic [PSR_W-1:0] FLAG_BITS = 32'hF000_0000;
    localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

endpackage

// File: rtl/brf_mode_dec.sv
module brf_mode_dec
    import brf_pkg::*;
(
    input  logic [4:0] mode_i,
    output bank_e      bank_o,
    output logic       priv_o,
    output logic       saved_o
);

    always_comb begin
        bank_o  = BK_USR;
        priv_o  = 1'b1;
        saved_o = 1'b1;
        case (mode_i)
            M_FIQ: bank_o = BK_FIQ;
            M_IRQ: bank_o = BK_IRQ;
            M_SVC: bank_o = BK_SVC;
            M_ABT: bank_o = BK_ABT;
            M_UND: bank_o = BK_UND;
            M_SYS: saved_o = 1'b0;
            default: begin
                // user mode and every unlisted code (R12)
                priv_o  = 1'b0;
                saved_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/brf_phys_map.sv
module brf_phys_map
    import brf_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  bank_e             bank_i,
    input  logic              priv_i,
    input  logic              usr_sel_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              is_pc_o
);

    bank_e eff_bank;
    int    slot;

    always_comb begin
        // R7: redirect to the user/system copies only when privileged
        eff_bank = (usr_sel_i && priv_i) ? BK_USR : bank_i;
        is_pc_o  = (idx_i == 4'hF);
        slot     = 0;
        if (idx_i < 4'd8) begin
            slot = int'(idx_i);
        end else if (idx_i < 4'd13) begin
            slot = ((eff_bank == BK_FIQ) ? FIQ_BASE : N_LOW) + int'(idx_i) - N_LOW;
        end else if (!is_pc_o) begin
            slot = PAIR_BASE + N_PAIR * int'(eff_bank) + int'(idx_i) - 13;
        end
        phys_o = PHYS_W'(slot);
    end

endmodule

// File: rtl/brf_psr.sv
module brf_psr
    import brf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psr_wr_i,
    input  logic             saved_sel_i,
    input  logic [PSR_W-1:0] wdata_i,
    input  logic             exc_take_i,
    input  logic [4:0]       exc_mode_i,
    input  logic             restore_i,
    output logic [PSR_W-1:0] cpsr_o,
    output logic [PSR_W-1:0] spsr_o,
    output bank_e            bank_o,
    output logic             priv_o
);

    typedef struct packed {
        logic [PSR_W-1:0]            cpsr;
        logic [N_EXC-1:0][PSR_W-1:0] spsr;
    } psr_t;

    psr_t s_d, s_q;

    bank_e      cur_bank, tgt_bank;
    logic       cur_priv, cur_saved, tgt_priv, tgt_saved, tgt_ok;
    logic [2:0] cur_slot, tgt_slot;

    brf_mode_dec u_cur_dec (
        .mode_i  (s_q.cpsr[4:0]),
        .bank_o  (cur_bank),
        .priv_o  (cur_priv),
        .saved_o (cur_saved)
    );

    brf_mode_dec u_tgt_dec (
        .mode_i  (exc_mode_i),
        .bank_o  (tgt_bank),
        .priv_o  (tgt_priv),
        .saved_o (tgt_saved)
    );

    assign tgt_ok   = tgt_saved && tgt_priv;
    assign cur_slot = cur_saved ? (3'(cur_bank) - 3'd1) : 3'd0;
    assign tgt_slot = tgt_ok    ? (3'(tgt_bank) - 3'd1) : 3'd0;

    always_comb begin
        s_d = s_q;
        if (exc_take_i && tgt_ok) begin
            // R8, R13: exception entry has the highest priority
            s_d.spsr[tgt_slot] = s_q.cpsr;
            s_d.cpsr[4:0]      = exc_mode_i;
            s_d.cpsr[7]        = 1'b1;
            if (tgt_bank == BK_FIQ) begin
                s_d.cpsr[6] = 1'b1;
            end
        end else if (restore_i && cur_saved) begin
            s_d.cpsr = s_q.spsr[cur_slot];
        end else if (psr_wr_i) begin
            if (saved_sel_i) begin
                if (cur_saved) begin
                    s_d.spsr[cur_slot] = wdata_i & PSR_KEEP;
                end
            end else if (cur_priv) begin
                s_d.cpsr = wdata_i & PSR_KEEP;
            end else begin
                s_d.cpsr = (s_q.cpsr & ~FLAG_BITS) | (wdata_i & FLAG_BITS);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cpsr <= PSR_RESET;
            s_q.spsr <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpsr_o = s_q.cpsr;
    assign spsr_o = cur_saved ? s_q.spsr[cur_slot] : '0;
    assign bank_o = cur_bank;
    assign priv_o = cur_priv;

    // R8: entry saves the old status and switches mode
    a_r8_entry_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take_i && tgt_ok) |=> (spsr_o == $past(cpsr_o)) && (cpsr_o[4:0] == $past(exc_mode_i)));

    // R9: unprivileged status writes touch only the flags
    a_r9_user_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_wr_i && !saved_sel_i && !cur_priv && !exc_take_i && !restore_i)
        |=> (cpsr_o[27:0] == $past(cpsr_o[27:0])));

    // R11: restore brings back the saved word
    a_r11_restore_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && cur_saved && !exc_take_i) |=> (cpsr_o == $past(spsr_o)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PC_AHEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              usr_bank,
    input  logic [DATA_W-1:0] pc_i,
    output logic [DATA_W-1:0] branch_o,
    output logic              flush_o,
    input  logic              psr_wr,
    input  logic              psr_saved_sel,
    input  logic [PSR_W-1:0]  psr_wdata,
    input  logic              exc_take,
    input  logic [4:0]        exc_mode,
    input  logic              psr_restore,
    output logic [PSR_W-1:0]  cpsr_o,
    output logic [PSR_W-1:0]  spsr_o
);

    localparam int N_PORT = 3;
    localparam int WP     = N_PORT - 1;

    typedef struct packed {
        logic [N_GPR-1:0][DATA_W-1:0] gpr;
        logic [DATA_W-1:0]            tgt;
        logic                         flush;
    } rf_t;

    rf_t s_d, s_q;

    bank_e cur_bank;
    logic  cur_priv;

    logic [N_PORT-1:0][IDX_W-1:0]  port_idx;
    logic [N_PORT-1:0][PHYS_W-1:0] port_phys;
    logic [N_PORT-1:0]             port_pc;

    brf_psr u_psr (
        .clk         (clk),
        .rst_n       (rst_n),
        .psr_wr_i    (psr_wr),
        .saved_sel_i (psr_saved_sel),
        .wdata_i     (psr_wdata),
        .exc_take_i  (exc_take),
        .exc_mode_i  (exc_mode),
        .restore_i   (psr_restore),
        .cpsr_o      (cpsr_o),
        .spsr_o      (spsr_o),
        .bank_o      (cur_bank),
        .priv_o      (cur_priv)
    );

    assign port_idx[0]  = rd_a_idx;
    assign port_idx[1]  = rd_b_idx;
    assign port_idx[WP] = wr_idx;

    for (genvar p = 0; p < N_PORT; p++) begin : g_map
        brf_phys_map u_map (
            .idx_i     (port_idx[p]),
            .bank_i    (cur_bank),
            .priv_i    (cur_priv),
            .usr_sel_i (usr_bank),
            .phys_o    (port_phys[p]),
            .is_pc_o   (port_pc[p])
        );
    end

    always_comb begin
        s_d       = s_q;
        s_d.flush = 1'b0;
        if (wr_en) begin
            if (port_pc[WP]) begin
                s_d.tgt   = wr_data;
                s_d.flush = 1'b1;
            end else begin
                s_d.gpr[port_phys[WP]] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // reads come from the stored state, so a same-cycle write is not seen (R6)
    assign rd_a_data = port_pc[0] ? (pc_i + DATA_W'(PC_AHEAD)) : s_q.gpr[port_phys[0]];
    assign rd_b_data = port_pc[1] ? (pc_i + DATA_W'(PC_AHEAD)) : s_q.gpr[port_phys[1]];
    assign branch_o  = s_q.tgt;
    assign flush_o   = s_q.flush;

    // R5: a write to number 15 is followed by one flush with the written target
    a_r5_flush_on_pc_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'hF) |=> (flush_o && branch_o == $past(wr_data)));

    // R5: no flush without a write to number 15
    a_r5_no_stray_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == 4'hF) |=> !flush_o);

    // R5: the target holds between writes to number 15
    a_r5_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == 4'hF) |=> $stable(branch_o));

endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

    localparam logic [4:0] C_USR = 5'b10000;
    localparam logic [4:0] C_FIQ = 5'b10001;
    localparam logic [4:0] C_IRQ = 5'b10010;
    localparam logic [4:0] C_SVC = 5'b10011;
    localparam logic [4:0] C_ABT = 5'b10111;
    localparam logic [4:0] C_UND = 5'b11011;
    localparam logic [4:0] C_SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_i = '0, branch_o;
    logic        wr_en = 1'b0, usr_bank = 1'b0, flush_o;
    logic        psr_wr = 1'b0, psr_saved_sel = 1'b0, exc_take = 1'b0, psr_restore = 1'b0;
    logic [31:0] psr_wdata = '0, cpsr_o, spsr_o;
    logic [4:0]  exc_mode = '0;

    int n_cmp = 0;
    int n_bad = 0;

    // expected contents: row 0 user/system, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
    logic [31:0] mdl [0:5][0:14];
    logic [4:0]  codes [0:6];

    always #2 clk = ~clk;

    banked_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .usr_bank(usr_bank), .pc_i(pc_i),
        .branch_o(branch_o), .flush_o(flush_o),
        .psr_wr(psr_wr), .psr_saved_sel(psr_saved_sel), .psr_wdata(psr_wdata),
        .exc_take(exc_take), .exc_mode(exc_mode), .psr_restore(psr_restore),
        .cpsr_o(cpsr_o), .spsr_o(spsr_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // owner row of a register number for a mode list position (0..6, 6 = system)
    function automatic int owner(input int mi, input int idx);
        if (idx < 8) return 0;
        if (idx < 13) return (mi == 1) ? 1 : 0;
        if (mi == 0 || mi == 6) return 0;
        return mi;
    endfunction

    task automatic psr_step(input logic wr, input logic sel, input logic [31:0] d,
                            input logic ex, input logic [4:0] em, input logic rs);
        @(negedge clk);
        psr_wr = wr; psr_saved_sel = sel; psr_wdata = d;
        exc_take = ex; exc_mode = em; psr_restore = rs;
        @(negedge clk);
        psr_wr = 0; psr_saved_sel = 0; psr_wdata = '0;
        exc_take = 0; exc_mode = '0; psr_restore = 0;
    endtask

    task automatic set_mode(input logic [4:0] code);
        psr_step(0, 0, '0, 1, C_SVC, 0);
        psr_step(1, 0, {27'd0, code}, 0, '0, 0);
    endtask

    task automatic write_reg(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic read_both(input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
        #1;
        chk({tag, " port A"}, rd_a_data, exp);
        chk({tag, " port B"}, rd_b_data, exp);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        codes[0] = C_USR; codes[1] = C_FIQ; codes[2] = C_IRQ; codes[3] = C_SVC;
        codes[4] = C_ABT; codes[5] = C_UND; codes[6] = C_SYS;
        for (int r = 0; r < 6; r++) for (int i = 0; i < 15; i++) mdl[r][i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 cpsr after reset", cpsr_o, 32'h0000_00D3);
        chk("R1 spsr after reset", spsr_o, 32'h0);
        chk("R1 flush after reset", {31'd0, flush_o}, 32'h0);
        for (int i = 0; i < 15; i++) read_both(i, 32'h0, "R1 register after reset");

        // R2 R3 R4: write every number in every mode with a mode/number tag
        for (int m = 0; m < 7; m++) begin
            set_mode(codes[m]);
            for (int i = 0; i < 15; i++) begin
                logic [31:0] v;
                v = 32'hA500_0000 | (32'(m) << 8) | 32'(i);
                write_reg(i, v);
                mdl[owner(m, i)][i] = v;
            end
        end
        // R2 R3 R4: read back every number in every mode
        for (int m = 0; m < 7; m++) begin
            set_mode(codes[m]);
            for (int i = 0; i < 15; i++)
                read_both(i, mdl[owner(m, i)][i],
                          (i < 8) ? "R2 shared low" : (i < 13) ? "R3 high bank" : "R4 stack/link bank");
        end

        // R5: program counter read
        pc_i = 32'h0000_0000; read_both(15, 32'h0000_0008, "R5 pc read");
        pc_i = 32'h0000_0100; read_both(15, 32'h0000_0108, "R5 pc read");
        pc_i = 32'hFFFF_FFFC; read_both(15, 32'h0000_0004, "R5 pc read wrap");

        // R6: same-cycle read and write, currently in system mode
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd3; wr_data = 32'h1357_9BDF; rd_a_idx = 4'd3;
        #1;
        chk("R6 read during write returns old", rd_a_data, mdl[0][3]);
        @(negedge clk);
        wr_en = 0;
        #1;
        mdl[0][3] = 32'h1357_9BDF;
        chk("R6 new value next cycle", rd_a_data, mdl[0][3]);

        // R5: write to number 15
        write_reg(15, 32'hDEAD_0040);
        #1;
        chk("R5 flush raised", {31'd0, flush_o}, 32'h1);
        chk("R5 branch target", branch_o, 32'hDEAD_0040);
        @(negedge clk); #1;
        chk("R5 flush one cycle", {31'd0, flush_o}, 32'h0);
        for (int i = 0; i < 15; i++) read_both(i, mdl[owner(6, i)][i], "R5 storage untouched");

        // R7: privileged access to user copies
        set_mode(C_IRQ);
        usr_bank = 1;
        read_both(13, mdl[0][13], "R7 irq sees user r13");
        usr_bank = 0;
        read_both(13, mdl[2][13], "R7 irq own r13");
        set_mode(C_FIQ);
        usr_bank = 1;
        read_both(8, mdl[0][8], "R7 fiq sees user r8");
        write_reg(14, 32'h7777_0014);
        mdl[0][14] = 32'h7777_0014;
        usr_bank = 0;
        read_both(14, mdl[1][14], "R7 fiq own r14 untouched");
        set_mode(C_SYS);
        read_both(14, 32'h7777_0014, "R7 user r14 written");
        set_mode(C_USR);
        usr_bank = 1;
        read_both(13, mdl[0][13], "R7 usr_bank ignored in user");
        usr_bank = 0;

        // R12: unlisted mode code acts as user
        set_mode(5'b10100);
        chk("R12 cpsr holds unlisted code", cpsr_o, 32'h0000_0014);
        read_both(13, mdl[0][13], "R12 unlisted mode uses user r13");
        read_both(8, mdl[0][8], "R12 unlisted mode uses shared r8");
        psr_step(1, 0, 32'h0000_00D3, 0, '0, 0);
        chk("R12 unlisted mode unprivileged", cpsr_o, 32'h0000_0014);

        // status section from a fresh reset
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        psr_step(1, 0, 32'h0000_0010, 0, '0, 0);
        chk("R9 privileged write to user", cpsr_o, 32'h0000_0010);
        psr_step(1, 0, 32'hFFFF_FFFF, 0, '0, 0);
        chk("R9 user write flags only", cpsr_o, 32'hF000_0010);
        psr_step(0, 0, '0, 0, '0, 1);
        chk("R11 restore ignored in user", cpsr_o, 32'hF000_0010);
        chk("R10 no saved word in user", spsr_o, 32'h0);
        psr_step(1, 1, 32'hFFFF_FFFF, 0, '0, 0);
        chk("R10 saved write ignored in user", spsr_o, 32'h0);
        psr_step(0, 0, '0, 1, C_SYS, 0);
        chk("R8 entry to system ignored", cpsr_o, 32'hF000_0010);
        psr_step(0, 0, '0, 1, 5'b00000, 0);
        chk("R8 entry to unlisted ignored", cpsr_o, 32'hF000_0010);
        psr_step(0, 0, '0, 1, C_IRQ, 0);
        chk("R8 entry irq cpsr", cpsr_o, 32'hF000_0092);
        chk("R8 entry irq saved", spsr_o, 32'hF000_0010);
        psr_step(0, 0, '0, 1, C_FIQ, 0);
        chk("R8 entry fiq cpsr", cpsr_o, 32'hF000_00D1);
        chk("R8 entry fiq saved", spsr_o, 32'hF000_0092);
        psr_step(0, 0, '0, 0, '0, 1);
        chk("R11 restore from fiq", cpsr_o, 32'hF000_0092);
        chk("R11 irq saved visible", spsr_o, 32'hF000_0010);
        psr_step(1, 1, 32'h6000_FFD3, 0, '0, 0);
        chk("R10 saved write masked", spsr_o, 32'h6000_00D3);
        psr_step(0, 0, '0, 0, '0, 1);
        chk("R11 restore to svc", cpsr_o, 32'h6000_00D3);
        chk("R10 svc saved untouched", spsr_o, 32'h0);
        psr_step(1, 0, 32'h0000_001F, 1, C_UND, 0);
        chk("R13 entry beats write cpsr", cpsr_o, 32'h6000_00DB);
        chk("R13 entry beats write saved", spsr_o, 32'h6000_00D3);
        psr_step(1, 0, 32'h0000_0010, 0, '0, 1);
        chk("R13 restore beats write", cpsr_o, 32'h6000_00D3);
        psr_step(1, 0, 32'h0000_001F, 0, '0, 0);
        chk("R9 privileged write to system", cpsr_o, 32'h0000_001F);
        psr_step(1, 1, 32'hFFFF_FFFF, 0, '0, 0);
        chk("R10 no saved word in system", spsr_o, 32'h0);
        psr_step(1, 0, 32'h0000_00D3, 0, '0, 0);
        chk("R10 svc saved unchanged by system write", spsr_o, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule